// File: doc/BRIEF.md
# Trace Port Control Register Bank

This block is the software-visible control and status register bank of a trace output unit. A host reaches it over a simple peripheral bus: a select, a write enable, a byte address, write data and read data. The bank keeps the current trace port width, the asynchronous baud prescaler, the pin-protocol selection, the formatter control bits and a small claim tag. It drives the live configuration out to the trace datapath on plain control pins. The bank holds only configuration; the formatter, the serialiser and the baud generator sit outside it.

Two behaviours make it more than a set of flops. The claim tag uses a set/clear pair on shared addresses: a read returns the mask or the tag, and a write sets or clears bits. The formatter control register reads back a fixed value while the parallel trace-port protocol is selected. The programmed value stays stored underneath and returns when a serial-wire protocol is selected again.

Writes commit on the rising clock edge when `bus_sel` and `bus_wr` are both high. Read data is combinational from the address while `bus_sel` is high and `bus_wr` is low, and is zero otherwise. Addresses are word aligned, so the two low address bits are ignored. No back-pressure exists: every access completes in the cycle it is presented.

Top module: `trc_ctl_regs`

## Requirements
- R1: After reset, the current width reads 0x1, the prescaler reads 0, the protocol reads 0x1, the formatter control reads 0x102 and the claim tag reads 0.
- R2: Offset 0x000 reads 0x0000000B (widths 1, 2 and 4 supported). Offset 0x300 reads 0x8. Offset 0x308 reads 0. Writes to these three offsets change nothing.
- R3: Offset 0x004 stores write-data bits 3:0 and reads them back with bits 31:4 zero. `port_width_oh` carries the stored value.
- R4: Offset 0x010 stores write-data bits 12:0 as the prescaler, and the upper bits read zero. `baud_div` carries the stored value; the divisor it implies is that value plus one.
- R5: Offset 0x0F0 stores write-data bits 1:0 as the protocol, and the upper bits read zero. `pin_proto` carries it; code 0 is the parallel trace port, and codes 1 to 3 are serial-wire modes.
- R6: Offset 0x304 stores write-data bit 8 (trigger insert) and bit 1 (continuous formatting), and all other bits read zero. While the protocol is 0, a read returns 0x102. With any other protocol it returns the stored bits.
- R7: `fmt_enable` is 1 while the protocol is 0, and otherwise equals the stored continuous-formatting bit.
- R8: Offset 0xFA0 reads 0x0000000F. A write there sets every claim-tag bit whose write-data bit (3:0) is 1 and leaves the others unchanged.
- R9: Offset 0xFA4 reads the 4-bit claim tag with bits 31:4 zero. A write there clears every claim-tag bit whose write-data bit (3:0) is 1. Write-data bits 31:4 have no effect.
- R10: Offset 0xFC8 reads 0xCA1 while `itrace_present` is 1 and 0xCA0 while it is 0.
- R11: Reads of any unmapped offset return 0. Writes to unmapped offsets change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| itrace_present | input | 1 | Static strap: instruction-trace source fitted |
| port_width_oh | output | 4 | Current port width enables |
| baud_div | output | 13 | Asynchronous prescaler value |
| pin_proto | output | 2 | Selected pin protocol |
| fmt_enable | output | 1 | Effective formatter enable |

## Verification
The assertions assume that `bus_sel`, `bus_wr` and `bus_addr` hold steady around each rising edge and are never unknown once reset is released. They also assume that `itrace_present` changes only while no read of the device-ID offset is in progress. The bench drives every bus signal on the falling edge and changes the strap only between accesses. It sweeps every word offset of the 4 KiB window, every claim-tag state against every set and clear mask, every protocol code against the formatter control contents, and every width code.

// File: rtl/trc_ctl_pkg.sv
package trc_ctl_pkg;

  // word offsets (byte offset / 4)
  localparam int unsigned WOFS_SUPP  = 32'h000 >> 2;
  localparam int unsigned WOFS_CUR   = 32'h004 >> 2;
  localparam int unsigned WOFS_PRESC = 32'h010 >> 2;
  localparam int unsigned WOFS_PROTO = 32'h0F0 >> 2;
  localparam int unsigned WOFS_FSTAT = 32'h300 >> 2;
  localparam int unsigned WOFS_FCTL  = 32'h304 >> 2;
  localparam int unsigned WOFS_SYNC  = 32'h308 >> 2;
  localparam int unsigned WOFS_CLSET = 32'hFA0 >> 2;
  localparam int unsigned WOFS_CLCLR = 32'hFA4 >> 2;
  localparam int unsigned WOFS_DEVID = 32'hFC8 >> 2;

  localparam logic [31:0] SUPP_VALUE  = 32'h0000_000B;
  localparam logic [31:0] FSTAT_VALUE = 32'h0000_0008;
  localparam logic [31:0] FCTL_FORCED = 32'h0000_0102;
  localparam logic [31:0] DEVID_BASE  = 32'h0000_0CA0;
  localparam int unsigned FCTL_TRIG_BIT = 8;
  localparam int unsigned FCTL_CONT_BIT = 1;
  localparam logic [1:0]  PROTO_PARALLEL = 2'd0;
  localparam logic [1:0]  PROTO_RESET    = 2'd1;

  typedef enum logic [3:0] {
    RSEL_NONE,
    RSEL_SUPP,
    RSEL_CUR,
    RSEL_PRESC,
    RSEL_PROTO,
    RSEL_FSTAT,
    RSEL_FCTL,
    RSEL_SYNC,
    RSEL_CLSET,
    RSEL_CLCLR,
    RSEL_DEVID
  } reg_sel_e;

endpackage

// File: rtl/trc_ctl_decode.sv
module trc_ctl_decode
  import trc_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam int unsigned WADDR_W = ADDR_W - 2;

  logic [WADDR_W-1:0] waddr;
  logic [1:0]         unused_low;

  assign waddr      = addr[ADDR_W-1:2];
  assign unused_low = addr[1:0];

  always_comb begin
    sel = RSEL_NONE;
    if      (waddr == WADDR_W'(WOFS_SUPP))  sel = RSEL_SUPP;
    else if (waddr == WADDR_W'(WOFS_CUR))   sel = RSEL_CUR;
    else if (waddr == WADDR_W'(WOFS_PRESC)) sel = RSEL_PRESC;
    else if (waddr == WADDR_W'(WOFS_PROTO)) sel = RSEL_PROTO;
    else if (waddr == WADDR_W'(WOFS_FSTAT)) sel = RSEL_FSTAT;
    else if (waddr == WADDR_W'(WOFS_FCTL))  sel = RSEL_FCTL;
    else if (waddr == WADDR_W'(WOFS_SYNC))  sel = RSEL_SYNC;
    else if (waddr == WADDR_W'(WOFS_CLSET)) sel = RSEL_CLSET;
    else if (waddr == WADDR_W'(WOFS_CLCLR)) sel = RSEL_CLCLR;
    else if (waddr == WADDR_W'(WOFS_DEVID)) sel = RSEL_DEVID;
  end

endmodule

// File: rtl/trc_ctl_claim.sv
module trc_ctl_claim #(
  parameter int unsigned CLAIM_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_stb,
  input  logic               clr_stb,
  input  logic [CLAIM_W-1:0] mask,
  output logic [CLAIM_W-1:0] tag
);

  for (genvar b = 0; b < CLAIM_W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     tag[b] <= 1'b0;
      else if (set_stb && mask[b])    tag[b] <= 1'b1;
      else if (clr_stb && mask[b])    tag[b] <= 1'b0;
    end
  end

  AST_CLAIM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((tag & $past(mask)) == $past(mask)) &&
                ((tag & ~$past(mask)) == ($past(tag) & ~$past(mask)))); // R8

  AST_CLAIM_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((tag & $past(mask)) == '0) &&
                ((tag & ~$past(mask)) == ($past(tag) & ~$past(mask)))); // R9

endmodule

// File: rtl/trc_ctl_fmt.sv
module trc_ctl_fmt
  import trc_ctl_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              trig_in,
  input  logic              cont_in,
  input  logic              proto_parallel,
  output logic [DATA_W-1:0] rd_val,
  output logic              fmt_en
);
  logic trig_q, cont_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= FCTL_FORCED[FCTL_TRIG_BIT];
      cont_q <= FCTL_FORCED[FCTL_CONT_BIT];
    end else if (wr_stb) begin
      trig_q <= trig_in;
      cont_q <= cont_in;
    end
  end

  always_comb begin
    rd_val = '0;
    if (proto_parallel) begin
      rd_val = DATA_W'(FCTL_FORCED);
    end else begin
      rd_val[FCTL_TRIG_BIT] = trig_q;
      rd_val[FCTL_CONT_BIT] = cont_q;
    end
  end

  assign fmt_en = proto_parallel | cont_q;

  AST_FMT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(trig_q) && $stable(cont_q)); // R6

endmodule

// File: rtl/trc_ctl_regs.sv
module trc_ctl_regs
  import trc_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned WIDTH_W = 4,
  parameter int unsigned PRESC_W = 13,
  parameter int unsigned PROTO_W = 2,
  parameter int unsigned CLAIM_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               itrace_present,
  output logic [WIDTH_W-1:0] port_width_oh,
  output logic [PRESC_W-1:0] baud_div,
  output logic [PROTO_W-1:0] pin_proto,
  output logic               fmt_enable
);
  localparam logic [DATA_W-1:0] CLAIM_MASK = DATA_W'((64'd1 << CLAIM_W) - 1);
  localparam logic [WIDTH_W-1:0] WIDTH_RESET = WIDTH_W'(1);

  reg_sel_e          rsel;
  logic              wr_go, rd_go;
  logic [WIDTH_W-1:0] width_q;
  logic [PRESC_W-1:0] presc_q;
  logic [PROTO_W-1:0] proto_q;
  logic [CLAIM_W-1:0] claim_q;
  logic [DATA_W-1:0]  fctl_rd;
  logic               proto_par;
  logic [DATA_W-1:0]  rd_mux;
  logic               unused_wdata;

  assign wr_go        = bus_sel & bus_wr;
  assign rd_go        = bus_sel & ~bus_wr;
  assign unused_wdata = ^bus_wdata;

  trc_ctl_decode #(.ADDR_W(ADDR_W)) i_decode (
    .addr (bus_addr),
    .sel  (rsel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q <= WIDTH_RESET;
      presc_q <= '0;
      proto_q <= PROTO_W'(PROTO_RESET);
    end else if (wr_go) begin
      case (rsel)
        RSEL_CUR:   width_q <= bus_wdata[WIDTH_W-1:0];
        RSEL_PRESC: presc_q <= bus_wdata[PRESC_W-1:0];
        RSEL_PROTO: proto_q <= bus_wdata[PROTO_W-1:0];
        default: ;
      endcase
    end
  end

  assign proto_par = (proto_q == PROTO_W'(PROTO_PARALLEL));

  trc_ctl_fmt #(.DATA_W(DATA_W)) i_fmt (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_stb         (wr_go && rsel == RSEL_FCTL),
    .trig_in        (bus_wdata[FCTL_TRIG_BIT]),
    .cont_in        (bus_wdata[FCTL_CONT_BIT]),
    .proto_parallel (proto_par),
    .rd_val         (fctl_rd),
    .fmt_en         (fmt_enable)
  );

  trc_ctl_claim #(.CLAIM_W(CLAIM_W)) i_claim (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_stb (wr_go && rsel == RSEL_CLSET),
    .clr_stb (wr_go && rsel == RSEL_CLCLR),
    .mask    (bus_wdata[CLAIM_W-1:0]),
    .tag     (claim_q)
  );

  always_comb begin
    rd_mux = '0;
    case (rsel)
      RSEL_SUPP:  rd_mux = DATA_W'(SUPP_VALUE);
      RSEL_CUR:   rd_mux = DATA_W'(width_q);
      RSEL_PRESC: rd_mux = DATA_W'(presc_q);
      RSEL_PROTO: rd_mux = DATA_W'(proto_q);
      RSEL_FSTAT: rd_mux = DATA_W'(FSTAT_VALUE);
      RSEL_FCTL:  rd_mux = fctl_rd;
      RSEL_SYNC:  rd_mux = '0;
      RSEL_CLSET: rd_mux = CLAIM_MASK;
      RSEL_CLCLR: rd_mux = DATA_W'(claim_q);
      RSEL_DEVID: rd_mux = DATA_W'(DEVID_BASE) | DATA_W'(itrace_present);
      default:    rd_mux = '0;
    endcase
  end

  assign bus_rdata     = rd_go ? rd_mux : '0;
  assign port_width_oh = width_q;
  assign baud_div      = presc_q;
  assign pin_proto     = proto_q;

  AST_FCTL_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && rsel == RSEL_FCTL && pin_proto == '0) |-> bus_rdata == DATA_W'(FCTL_FORCED)); // R6

  AST_FMT_EN_PARALLEL: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_proto == '0) |-> fmt_enable); // R7

  AST_PROTO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_go && rsel == RSEL_PROTO) |=> $stable(pin_proto)); // R5

  AST_RO_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && (rsel == RSEL_NONE || rsel == RSEL_SUPP || rsel == RSEL_FSTAT ||
               rsel == RSEL_SYNC || rsel == RSEL_DEVID))
    |=> $stable(port_width_oh) && $stable(baud_div) && $stable(pin_proto) &&
        $stable(fmt_enable) && $stable(claim_q)); // R11

  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |-> bus_rdata == '0); // R11

endmodule

// File: tb/test_trc_ctl_regs.sv
module test_trc_ctl_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        itrace_present = 1'b0;
  logic [3:0]  port_width_oh;
  logic [12:0] baud_div;
  logic [1:0]  pin_proto;
  logic        fmt_enable;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  // shadow model
  logic [3:0]  m_width;
  logic [12:0] m_presc;
  logic [1:0]  m_proto;
  logic        m_trig, m_cont;
  logic [3:0]  m_claim;

  trc_ctl_regs i_trc_ctl_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .itrace_present(itrace_present), .port_width_oh(port_width_oh),
    .baud_div(baud_div), .pin_proto(pin_proto), .fmt_enable(fmt_enable)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  function automatic logic [31:0] exp_read(logic [11:0] a);
    case (a & 12'hFFC)
      12'h000: return 32'hB;
      12'h004: return {28'd0, m_width};
      12'h010: return {19'd0, m_presc};
      12'h0F0: return {30'd0, m_proto};
      12'h300: return 32'h8;
      12'h304: return (m_proto == 2'd0) ? 32'h102
                      : ((32'(m_trig) << 8) | (32'(m_cont) << 1));
      12'h308: return 32'h0;
      12'hFA0: return 32'hF;
      12'hFA4: return {28'd0, m_claim};
      12'hFC8: return itrace_present ? 32'hCA1 : 32'hCA0;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check_outputs(string req);
    check({req, " width"}, 32'(port_width_oh), 32'(m_width));
    check({req, " baud"},  32'(baud_div),      32'(m_presc));
    check({req, " proto"}, 32'(pin_proto),     32'(m_proto));
    check({req, " fmt_en"}, 32'(fmt_enable),
          32'((m_proto == 2'd0) | m_cont));
  endtask

  initial begin
    logic [31:0] d;
    m_width = 4'h1; m_presc = '0; m_proto = 2'd1;
    m_trig = 1'b1; m_cont = 1'b1; m_claim = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(12'h004, d); check("R1 width", d, 32'h1);
    rd(12'h010, d); check("R1 presc", d, 32'h0);
    rd(12'h0F0, d); check("R1 proto", d, 32'h1);
    rd(12'h304, d); check("R1 fctl", d, 32'h102);
    rd(12'hFA4, d); check("R1 claim", d, 32'h0);
    check_outputs("R1");

    // R2 fixed registers ignore writes
    wr(12'h000, 32'hFFFF_FFFF); wr(12'h300, 32'hFFFF_FFFF); wr(12'h308, 32'hFFFF_FFFF);
    rd(12'h000, d); check("R2 supp", d, 32'hB);
    rd(12'h300, d); check("R2 fstat", d, 32'h8);
    rd(12'h308, d); check("R2 sync", d, 32'h0);
    check_outputs("R2");

    // R3 every width code
    for (int v = 0; v < 16; v++) begin
      wr(12'h004, 32'hFFFF_FFF0 | 32'(v));
      m_width = 4'(v);
      rd(12'h004, d); check("R3 readback", d, 32'(v));
      check_outputs("R3");
    end
    wr(12'h004, 32'h1); m_width = 4'h1;

    // R4 prescaler values
    for (int k = 0; k < 14; k++) begin
      logic [31:0] w;
      w = (k == 13) ? 32'hFFFF_FFFF : (32'h1 << k);
      wr(12'h010, w);
      m_presc = w[12:0];
      rd(12'h010, d); check("R4 presc", d, 32'(m_presc));
      check_outputs("R4");
    end

    // R5 R6 R7 protocol x formatter control sweep
    for (int p = 0; p < 4; p++) begin
      for (int f = 0; f < 4; f++) begin
        wr(12'h0F0, 32'hFFFF_FFFC | 32'(p));
        m_proto = 2'(p);
        wr(12'h304, 32'hFFFF_FEFD | (32'(f[1]) << 8) | (32'(f[0]) << 1));
        m_trig = f[1]; m_cont = f[0];
        rd(12'h0F0, d); check("R5 proto", d, 32'(p));
        rd(12'h304, d); check("R6 fctl readback", d, exp_read(12'h304));
        check_outputs("R7");
      end
    end
    // R6 stored value survives a trip through parallel mode
    wr(12'h0F0, 32'h2); m_proto = 2'd2;
    wr(12'h304, 32'h100); m_trig = 1'b1; m_cont = 1'b0;
    wr(12'h0F0, 32'h0); m_proto = 2'd0;
    rd(12'h304, d); check("R6 forced", d, 32'h102);
    check_outputs("R7 parallel");
    wr(12'h0F0, 32'h3); m_proto = 2'd3;
    rd(12'h304, d); check("R6 restored", d, 32'h100);
    check_outputs("R7 serial");

    // R8 R9 claim tag exhaustive
    for (int s = 0; s < 16; s++) begin
      for (int w = 0; w < 16; w++) begin
        wr(12'hFA4, 32'hF); wr(12'hFA0, 32'(s));
        wr(12'hFA0, 32'hFFFF_FFF0 | 32'(w));
        rd(12'hFA4, d); check("R8 set", d, 32'(s | w));
        wr(12'hFA4, 32'hF); wr(12'hFA0, 32'(s));
        wr(12'hFA4, 32'hFFFF_FFF0 | 32'(w));
        rd(12'hFA4, d); check("R9 clear", d, 32'(s & ~w & 15));
      end
    end
    m_claim = 4'(15 & ~15);
    rd(12'hFA0, d); check("R8 mask", d, 32'hF);

    // R10 device id
    itrace_present = 1'b0;
    rd(12'hFC8, d); check("R10 no trace", d, 32'hCA0);
    itrace_present = 1'b1;
    rd(12'hFC8, d); check("R10 trace", d, 32'hCA1);

    // R11 full address sweep, writes to unmapped then reads
    wr(12'hFA0, 32'h5); m_claim = 4'h5;
    for (int i = 0; i < 1024; i++) begin
      logic [11:0] a;
      a = 12'(i * 4);
      if (exp_read(a) == 32'h0 && a != 12'h308 && a != 12'h004 &&
          a != 12'h010 && a != 12'h0F0 && a != 12'h304 && a != 12'hFA4)
        wr(a, 32'hFFFF_FFFF);
    end
    for (int i = 0; i < 1024; i++) begin
      logic [11:0] a;
      a = 12'(i * 4);
      rd(a, d); check("R11 sweep", d, exp_read(a));
    end
    check_outputs("R11");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule